// File: doc/BRIEF.md
# Pi/4-DQPSK Burst Transmit Sequencer

This block turns host-supplied transmit bytes into a stream of differentially encoded pi/4-shifted QPSK symbols, one symbol every two sample-tick periods. The host loads a one-byte holding register. Each byte is moved into a shift register and consumed two bits at a time, most significant pair first. Every bit pair advances a 3-bit phase index, and the index selects a signed I/Q code pair from an eight-point constellation. The pair is presented with a one-cycle strobe.

A single level input starts and stops bursts of any length. After the start, a 2-bit offset delays the first symbol by 0 to 3 extra ticks. The go level is sampled only at symbol boundaries. When it is seen low there, the burst stops, so the last symbol lies two ticks before the stop tick. The outputs are then held at zero for a fixed number of ticks. The power-amplifier enable is asserted for the whole burst and is gated off while the synthesizer reports loss of lock. If the host has not refilled the holding register when a new byte is needed, the block sends zero bit pairs and raises a sticky underrun flag.

Filtering, conversion and analog ramp shaping are left to later stages.

Top module: `dqpsk_burst_tx`

## Requirements
- R1: After reset, sym_i and sym_q are 0, sym_stb, pa_en, burst_on, zero_hold and underrun are 0, and dat_empty is 1.
- R2: Each bit pair adds to the phase index, modulo 8: 00 adds 1, 01 adds 3, 11 adds 5 and 10 adds 7. Phase k drives (I,Q) as follows, with A = AMP and D = (AMP*181+128)/256: k=0 gives (A,0), 1 gives (D,D), 2 gives (0,A), 3 gives (-D,D), 4 gives (-A,0), 5 gives (-D,-D), 6 gives (0,-A), 7 gives (D,-D).
- R3: A byte written with dat_we is consumed most significant pair first. It moves to the shift register when a symbol needs a pair and the shift register is empty. dat_empty is 1 while the holding register is unloaded. A byte written during a burst continues the same phase sequence.
- R4: Within a burst, sym_stb pulses for exactly one clock per emitted symbol, and symbols are emitted on every second tick.
- R5: A burst starts at a tick where tx_go is high while the block is idle. Counting that start tick as tick 0, the first symbol is emitted at tick 2 + ofs_sel. The phase index restarts at 0 for every burst.
- R6: tx_go is sampled only at symbol-boundary ticks. When it is low there, no symbol is sent and zero_hold starts, so the first zero_hold tick is three ticks after the last symbol's tick.
- R7: zero_hold lasts exactly HOLD_TICKS ticks with zero outputs, and tx_go is ignored while it lasts. burst_on falls afterwards.
- R8: pa_en equals burst_on with the loss-of-lock input pll_unlock low.
- R9: A symbol that finds both the shift and holding registers empty sends bit pair 00 and sets underrun. underrun stays set until the next burst start.
- R10: sym_i and sym_q are 0 whenever the block is not emitting a burst (idle, offset delay and hold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample-tick strobe |
| tx_go | input | 1 | Burst run level |
| ofs_sel | input | OFS_W | Start offset in ticks |
| pll_unlock | input | 1 | Synthesizer out-of-lock, high blocks the PA enable |
| dat_we | input | 1 | Holding-register write strobe |
| dat_in | input | 8 | Byte to transmit |
| dat_empty | output | 1 | Holding register needs a byte |
| sym_i | output | DW | Signed I code |
| sym_q | output | DW | Signed Q code |
| sym_stb | output | 1 | New symbol strobe |
| pa_en | output | 1 | Power-amplifier enable |
| burst_on | output | 1 | Burst in progress, including delay and hold |
| zero_hold | output | 1 | Post-burst zero hold in progress |
| underrun | output | 1 | Sticky data-underrun flag |

## Verification
The bench uses the default parameters: 10-bit codes, AMP of 384 so the diagonal code is 272, and a hold of six ticks. It issues a sample tick every fourth clock, so a full burst with its offset and hold finishes in a few hundred cycles. All four offset codes and all four bit-pair increments appear in the vector table. This lets the bench check each of the eight constellation points, the start delay and the stop spacing exactly. Directed bursts cover a chained second byte, underrun with its sticky flag, lock gating, and go pulses during the hold.

// File: rtl/dqpsk_burst_tx.sv
module dqpsk_burst_tx #(
  parameter int DW         = 10,
  parameter int AMP        = 384,
  parameter int HOLD_TICKS = 6,
  parameter int OFS_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_tick,
  input  logic                 tx_go,
  input  logic [OFS_W-1:0]     ofs_sel,
  input  logic                 pll_unlock,
  input  logic                 dat_we,
  input  logic [7:0]           dat_in,
  output logic                 dat_empty,
  output logic signed [DW-1:0] sym_i,
  output logic signed [DW-1:0] sym_q,
  output logic                 sym_stb,
  output logic                 pa_en,
  output logic                 burst_on,
  output logic                 zero_hold,
  output logic                 underrun
);
  localparam int DIAG = (AMP * 181 + 128) / 256;
  localparam int HW   = $clog2(HOLD_TICKS + 1);
  localparam logic signed [DW-1:0] C_FULL = DW'(AMP);
  localparam logic signed [DW-1:0] C_DIAG = DW'(DIAG);
  localparam logic signed [DW-1:0] C_ZERO = '0;

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_RUN, S_HOLD} st_t;

  st_t              st;
  logic [OFS_W-1:0] ofs_cnt;
  logic [HW-1:0]    hcnt;
  logic             half;
  logic [2:0]       phase;
  logic [7:0]       shreg, hold_q;
  logic [1:0]       nbits;
  logic             full, urun_q, stb_q;
  logic signed [DW-1:0] i_q, q_q;

  function automatic logic signed [DW-1:0] lut_i(input logic [2:0] p);
    case (p)
      3'd0:    return C_FULL;
      3'd1:    return C_DIAG;
      3'd3:    return -C_DIAG;
      3'd4:    return -C_FULL;
      3'd5:    return -C_DIAG;
      3'd7:    return C_DIAG;
      default: return C_ZERO;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] lut_q(input logic [2:0] p);
    case (p)
      3'd1:    return C_DIAG;
      3'd2:    return C_FULL;
      3'd3:    return C_DIAG;
      3'd5:    return -C_DIAG;
      3'd6:    return -C_FULL;
      3'd7:    return -C_DIAG;
      default: return C_ZERO;
    endcase
  endfunction

  logic       boundary, emit, stop, start;
  logic [1:0] dibit;
  logic [2:0] inc, nxt_phase;

  assign start    = (st == S_IDLE) && smp_tick && tx_go;
  assign boundary = (st == S_RUN) && smp_tick && !half;
  assign emit     = boundary && tx_go;
  assign stop     = boundary && !tx_go;
  assign dibit    = (nbits != 2'd0) ? shreg[7:6] : (full ? hold_q[7:6] : 2'b00);

  always_comb begin
    case (dibit)
      2'b00:   inc = 3'd1;
      2'b01:   inc = 3'd3;
      2'b11:   inc = 3'd5;
      default: inc = 3'd7;
    endcase
  end
  assign nxt_phase = phase + inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ofs_cnt <= '0; hcnt <= '0; half <= 1'b0;
      phase <= '0; shreg <= '0; hold_q <= '0; nbits <= '0;
      full <= 1'b0; urun_q <= 1'b0; stb_q <= 1'b0;
      i_q <= '0; q_q <= '0;
    end else begin
      stb_q <= emit;
      if (dat_we) begin
        hold_q <= dat_in;
        full   <= 1'b1;
      end else if (emit && nbits == 2'd0 && full) begin
        full <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_DLY; ofs_cnt <= ofs_sel; phase <= '0;
          nbits <= '0; urun_q <= 1'b0; half <= 1'b0;
        end
        S_DLY: if (smp_tick) begin
          if (ofs_cnt == '0) begin
            st <= S_RUN; half <= 1'b0;
          end else begin
            ofs_cnt <= ofs_cnt - OFS_W'(1);
          end
        end
        S_RUN: if (smp_tick) begin
          half <= ~half;
          if (emit) begin
            phase <= nxt_phase;
            i_q   <= lut_i(nxt_phase);
            q_q   <= lut_q(nxt_phase);
            if (nbits != 2'd0) begin
              shreg <= {shreg[5:0], 2'b00};
              nbits <= nbits - 2'd1;
            end else if (full) begin
              shreg <= {hold_q[5:0], 2'b00};
              nbits <= 2'd3;
            end else begin
              urun_q <= 1'b1;
            end
          end
          if (stop) begin
            st <= S_HOLD; hcnt <= HW'(HOLD_TICKS);
            i_q <= '0; q_q <= '0;
          end
        end
        default: if (smp_tick) begin
          if (hcnt <= HW'(1)) st <= S_IDLE;
          hcnt <= hcnt - HW'(1);
        end
      endcase
    end
  end

  assign dat_empty = ~full;
  assign sym_i     = i_q;
  assign sym_q     = q_q;
  assign sym_stb   = stb_q;
  assign burst_on  = (st != S_IDLE);
  assign zero_hold = (st == S_HOLD);
  assign underrun  = urun_q;
  assign pa_en     = burst_on & ~pll_unlock;

  logic axis_last, seen_sym, axis_now;
  assign axis_now = (sym_i == '0) || (sym_q == '0);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      axis_last <= 1'b0; seen_sym <= 1'b0;
    end else if (start) begin
      seen_sym <= 1'b0;
    end else if (sym_stb) begin
      seen_sym <= 1'b1; axis_last <= axis_now;
    end
  end

  // R4
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);
  // R2
  pi4_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && seen_sym) |-> (axis_now != axis_last));
  // R10
  zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |-> (sym_i == '0 && sym_q == '0));
  // R6
  stop_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_hold) |-> ($past(st) == S_RUN && !$past(tx_go)));
  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underrun) |-> (st == S_DLY));
  // R8
  pa_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_en) |-> burst_on);
endmodule

// File: tb/dqpsk_burst_tx_bench.sv
module dqpsk_burst_tx_bench;
  localparam int AMP  = 384;
  localparam int DIAG = (AMP * 181 + 128) / 256;

  logic clk = 1'b0, rst_n = 1'b0, smp_tick = 1'b0, tx_go = 1'b0;
  logic [1:0] ofs_sel = '0;
  logic pll_unlock = 1'b0, dat_we = 1'b0;
  logic [7:0] dat_in = '0;
  logic dat_empty, sym_stb, pa_en, burst_on, zero_hold, underrun;
  logic signed [9:0] sym_i, sym_q;

  dqpsk_burst_tx u_dqpsk_burst_tx (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .tx_go(tx_go),
    .ofs_sel(ofs_sel), .pll_unlock(pll_unlock), .dat_we(dat_we),
    .dat_in(dat_in), .dat_empty(dat_empty), .sym_i(sym_i), .sym_q(sym_q),
    .sym_stb(sym_stb), .pa_en(pa_en), .burst_on(burst_on),
    .zero_hold(zero_hold), .underrun(underrun));

  always #4 clk = ~clk;

  int div = 0;
  always @(negedge clk) begin
    smp_tick <= (div == 3);
    div <= (div == 3) ? 0 : div + 1;
  end

  int tk = 0, start_tk = 0, first_zh = 0, last_zh = 0;
  logic zhp = 1'b0;
  always @(posedge clk) if (smp_tick) begin
    tk <= tk + 1;
    zhp <= zero_hold;
    if (zero_hold && !zhp) first_zh <= tk + 1;
    if (zero_hold) last_zh <= tk + 1;
    if (tx_go && !burst_on) start_tk <= tk + 1;
  end

  int stb_cnt = 0;
  int got_i [64];
  int got_q [64];
  int got_tk [64];
  always @(negedge clk) if (sym_stb && stb_cnt < 64) begin
    got_i[stb_cnt] = int'(sym_i);
    got_q[stb_cnt] = int'(sym_q);
    got_tk[stb_cnt] = tk;
    stb_cnt = stb_cnt + 1;
  end

  int total = 0, bad = 0;
  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ei(input int p);
    case (p)
      0: return AMP; 1: return DIAG; 3: return -DIAG; 4: return -AMP;
      5: return -DIAG; 7: return DIAG; default: return 0;
    endcase
  endfunction
  function automatic int eq(input int p);
    case (p)
      1: return DIAG; 2: return AMP; 3: return DIAG; 5: return -DIAG;
      6: return -AMP; 7: return -DIAG; default: return 0;
    endcase
  endfunction

  // {ofs, byte, phase0..phase3}
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 8'h1B, 3'd1, 3'd4, 3'd3, 3'd0},
    {2'd1, 8'hE4, 3'd5, 3'd4, 3'd7, 3'd0},
    {2'd2, 8'h00, 3'd1, 3'd2, 3'd3, 3'd4},
    {2'd3, 8'hFF, 3'd5, 3'd2, 3'd7, 3'd4},
    {2'd0, 8'hAA, 3'd7, 3'd6, 3'd5, 3'd4},
    {2'd1, 8'h55, 3'd3, 3'd6, 3'd1, 3'd4}
  };

  int base = 0;

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); dat_in = b; dat_we = 1'b1;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic sym_chk(input string tag, input int idx, input int ph);
    chk({tag, " I"}, got_i[idx], ei(ph));
    chk({tag, " Q"}, got_q[idx], eq(ph));
  endtask

  initial begin
    int watchdog_hit;
    watchdog_hit = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sym_i", int'(sym_i), 0);
    chk("R1 sym_q", int'(sym_q), 0);
    chk("R1 flags", {sym_stb, pa_en, burst_on, zero_hold, underrun}, 0);
    chk("R1 dat_empty", dat_empty, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      write_byte(VEC[v][19:12]);
      chk("R3 dat_empty after write", dat_empty, 0);
      ofs_sel = VEC[v][21:20];
      base = stb_cnt;
      tx_go = 1'b1;
      wait (stb_cnt == base + 4);
      tx_go = 1'b0;
      wait (!burst_on);
      @(negedge clk);
      for (int s = 0; s < 4; s++)
        sym_chk("R2 vector symbol", base + s, int'(VEC[v][11 - 3*s -: 3]));
      chk("R5 first symbol tick", got_tk[base] - start_tk, 2 + int'(VEC[v][21:20]));
      chk("R4 symbol spacing", got_tk[base + 3] - got_tk[base], 6);
      chk("R6 stop spacing", first_zh - got_tk[base + 3], 3);
      chk("R7 hold ticks", last_zh - first_zh + 1, 6);
      chk("R9 no underrun", underrun, 0);
      chk("R3 dat_empty after load", dat_empty, 1);
      chk("R10 idle zero", int'(sym_i) + int'(sym_q), 0);
      repeat (3) @(negedge clk);
    end

    // R3 chained second byte
    write_byte(8'h1B);
    ofs_sel = 2'd0;
    base = stb_cnt;
    tx_go = 1'b1;
    wait (stb_cnt == base + 1);
    @(negedge clk);
    chk("R3 empty after first load", dat_empty, 1);
    dat_in = 8'hE4; dat_we = 1'b1;
    @(negedge clk); dat_we = 1'b0;
    chk("R3 full after second write", dat_empty, 0);
    // R8 lock gating
    pll_unlock = 1'b1;
    @(negedge clk);
    chk("R8 pa_en gated", pa_en, 0);
    pll_unlock = 1'b0;
    @(negedge clk);
    chk("R8 pa_en on", pa_en, 1);
    wait (stb_cnt == base + 8);
    tx_go = 1'b0;
    wait (zero_hold);
    @(negedge clk);
    chk("R10 zero in hold", int'(sym_i) + int'(sym_q), 0);
    // R7 go ignored during hold
    tx_go = 1'b1;
    repeat (8) @(negedge clk);
    tx_go = 1'b0;
    wait (!burst_on);
    repeat (12) @(negedge clk);
    chk("R7 hold ticks with go pulse", last_zh - first_zh + 1, 6);
    chk("R7 no symbol during hold", stb_cnt - base, 8);
    chk("R7 no restart", burst_on, 0);
    chk("R8 pa_en idle", pa_en, 0);
    sym_chk("R3 chain s4", base + 4, 5);
    sym_chk("R3 chain s5", base + 5, 4);
    sym_chk("R3 chain s6", base + 6, 7);
    sym_chk("R3 chain s7", base + 7, 0);

    // R9 underrun
    write_byte(8'h00);
    ofs_sel = 2'd2;
    base = stb_cnt;
    tx_go = 1'b1;
    wait (stb_cnt == base + 4);
    @(negedge clk);
    chk("R9 no underrun yet", underrun, 0);
    wait (stb_cnt == base + 6);
    tx_go = 1'b0;
    @(negedge clk);
    chk("R9 underrun set", underrun, 1);
    wait (!burst_on);
    @(negedge clk);
    chk("R9 underrun sticky", underrun, 1);
    sym_chk("R9 zero pair s4", base + 4, 5);
    sym_chk("R9 zero pair s5", base + 5, 6);
    write_byte(8'h55);
    base = stb_cnt;
    tx_go = 1'b1;
    wait (stb_cnt == base + 1);
    @(negedge clk);
    chk("R9 cleared on start", underrun, 0);
    sym_chk("R5 phase restart", base, 3);
    tx_go = 1'b0;
    wait (!burst_on);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule